// File: doc/BRIEF.md
# Scanline-Split CHR Bank Mapper

This block is the bank-selection logic of a game cartridge mapper. The CPU writes four byte-wide configuration registers through a 1 KiB window at 0x5000–0x53FF. From their fields and a fixed outer-bank offset, the block forms the number of the 32 KiB program (PRG) bank that is mapped at 0x8000. The outer-bank offset comes from a surrounding multi-game register.

The block also chooses the pattern-table (CHR) banks for each scanline. A small state machine updates the two 4 KiB CHR bank numbers once per line, when it sees the scanline-start strobe. In split mode, both pattern halves show 4 KiB page 0 at the top of the visible frame and page 1 from a set scanline down. This gives a split-screen tile set with no CPU write mid-frame. Outside split mode, and outside the visible lines, the pattern tables map one plain 8 KiB bank: page 0 low and page 1 high.

The state machine has three states:
- `SPLIT_FLAT`: 8 KiB bank 0, so lo=0 and hi=1.
- `SPLIT_TOP`: both halves on page 0.
- `SPLIT_BOTTOM`: both halves on page 1.

The state machine changes state only on a strobe or on a clear:
- A clear moves it to `SPLIT_FLAT` from any state.
- A strobe moves it to `SPLIT_FLAT` when split mode is off or the line is 239 or later.
- A strobe moves it to `SPLIT_TOP` when split mode is on and the line is below 127.
- A strobe moves it to `SPLIT_BOTTOM` when split mode is on and the line is 127 through 238.
- In every other cycle it keeps its state.

Top module: `chr_split_mapper`

## Requirements
- R1: A write with `wr_en` high and `cpu_addr_hi[7:2]` equal to 6'b010100 (CPU address 0x5000–0x53FF) loads `wr_data` into register `cpu_addr_hi[1:0]`. Writes with any other address change no register.
- R2: `prg_bank` = {reg2[1:0], 4'b0000} OR reg0[3:0] OR fill OR (`outer_prg` >> 2). A register write shows on `prg_bank` right after the clock edge that takes it.
- R3: The fill term is 2'b00 when reg3 bit 2 is 1 and 2'b11 when reg3 bit 2 is 0.
- R4: When reg0 bit 7 is 1 and a `line_start` strobe comes with `scanline` below 127, both `chr_lo_bank` and `chr_hi_bank` become 0.
- R5: When reg0 bit 7 is 1 and a strobe comes with `scanline` from 127 to 238, both CHR outputs become 1.
- R6: When a strobe comes with reg0 bit 7 equal to 0, or with `scanline` of 239 or more, the outputs become `chr_lo_bank`=0 and `chr_hi_bank`=1.
- R7: The CHR outputs change only on the clock edge that samples `line_start` or `clear` high. Register writes and scanline changes alone leave them unchanged.
- R8: `mirror_horiz` follows `mirror_sel` (1 = horizontal, 0 = vertical).
- R9: Reset, and a `clear` pulse (which wins over a write in the same cycle), set all four registers to zero and the CHR outputs to lo=0, hi=1. So `prg_bank` becomes 0x03 OR (`outer_prg` >> 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Mode applied with register clear |
| wr_en | input | 1 | CPU write strobe, one cycle |
| cpu_addr_hi | input | 8 | CPU address bits 15:8 |
| wr_data | input | 8 | CPU write data |
| line_start | input | 1 | Scanline-start strobe |
| scanline | input | 9 | Current scanline number |
| outer_prg | input | 8 | Outer PRG offset from multi-game register |
| mirror_sel | input | 1 | External mirroring select bit |
| prg_bank | output | 8 | 32 KiB PRG bank number |
| chr_lo_bank | output | 4 | 4 KiB CHR page for 0x0000 |
| chr_hi_bank | output | 4 | 4 KiB CHR page for 0x1000 |
| mirror_horiz | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
The bench builds the block with its default parameters:
- An 8-bit outer offset and an 8-bit PRG bank, so an outer value of 0x80 sets bank bit 5. This checks the OR with the register fields where they overlap.
- A 9-bit scanline, so values up to 511 can be driven. This covers the vertical-blank lines past 239.
- A split line of 127 and a visible-end line of 239. These let the strobes at 126/127 and 238/239 test each side of both thresholds.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        SPLIT_FLAT   = 2'd0,
        SPLIT_TOP    = 2'd1,
        SPLIT_BOTTOM = 2'd2
    } split_state_e;

    localparam int CFG_REGS = 4;
    typedef logic [7:0] cfg_byte_t;

endpackage

// File: rtl/csm_regs.sv
module csm_regs
    import csm_pkg::*;
#(
    parameter logic [5:0] WIN_TAG = 6'b010100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       wr_en,
    input  logic [7:0] cpu_addr_hi,
    input  logic [7:0] wr_data,
    output logic [3:0] bank_low,
    output logic       split_en,
    output logic [1:0] bank_high,
    output logic       fill_off
);

    cfg_byte_t cfg_q [CFG_REGS];
    logic      in_window;

    assign in_window = (cpu_addr_hi[7:2] == WIN_TAG);

    for (genvar g = 0; g < CFG_REGS; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (clear) begin
                cfg_q[g] <= '0;
            end else if (wr_en && in_window && (cpu_addr_hi[1:0] == 2'(g))) begin
                cfg_q[g] <= wr_data;
            end
        end
    end

    assign bank_low  = cfg_q[0][3:0];
    assign split_en  = cfg_q[0][7];
    assign bank_high = cfg_q[2][1:0];
    assign fill_off  = cfg_q[3][2];

endmodule

// File: rtl/csm_prg.sv
module csm_prg #(
    parameter int OUTER_W = 8,
    parameter int PRG_W   = 8
) (
    input  logic [3:0]         bank_low,
    input  logic [1:0]         bank_high,
    input  logic               fill_off,
    input  logic [OUTER_W-1:0] outer_prg,
    output logic [PRG_W-1:0]   prg_bank
);

    localparam int OUTER_SHIFT = 2;

    logic [PRG_W-1:0] inner_part;
    logic [PRG_W-1:0] fill_part;
    logic [PRG_W-1:0] outer_part;

    always_comb begin
        inner_part = PRG_W'({bank_high, bank_low});
        fill_part  = fill_off ? '0 : PRG_W'(2'b11);
        outer_part = PRG_W'(outer_prg >> OUTER_SHIFT);
        prg_bank   = inner_part | fill_part | outer_part;
    end

endmodule

// File: rtl/csm_chr_fsm.sv
module csm_chr_fsm
    import csm_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int CHR_W      = 4,
    parameter int SPLIT_LINE = 127,
    parameter int VIS_END    = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              line_start,
    input  logic [LINE_W-1:0] scanline,
    input  logic              split_en,
    output logic [CHR_W-1:0]  chr_lo_bank,
    output logic [CHR_W-1:0]  chr_hi_bank
);

    split_state_e state_q, state_d;
    logic         past_split, past_visible;

    assign past_split   = (scanline >= LINE_W'(SPLIT_LINE));
    assign past_visible = (scanline >= LINE_W'(VIS_END));

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = SPLIT_FLAT;
        end else if (line_start) begin
            if (!split_en || past_visible) begin
                state_d = SPLIT_FLAT;
            end else if (past_split) begin
                state_d = SPLIT_BOTTOM;
            end else begin
                state_d = SPLIT_TOP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SPLIT_FLAT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SPLIT_FLAT: begin
                chr_lo_bank = CHR_W'(0);
                chr_hi_bank = CHR_W'(1);
            end
            SPLIT_TOP: begin
                chr_lo_bank = CHR_W'(0);
                chr_hi_bank = CHR_W'(0);
            end
            SPLIT_BOTTOM: begin
                chr_lo_bank = CHR_W'(1);
                chr_hi_bank = CHR_W'(1);
            end
            default: begin
                chr_lo_bank = CHR_W'(0);
                chr_hi_bank = CHR_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/chr_split_mapper.sv
module chr_split_mapper #(
    parameter int         OUTER_W    = 8,
    parameter int         PRG_W      = 8,
    parameter int         LINE_W     = 9,
    parameter int         CHR_W      = 4,
    parameter int         SPLIT_LINE = 127,
    parameter int         VIS_END    = 239,
    parameter logic [5:0] WIN_TAG    = 6'b010100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [7:0]         cpu_addr_hi,
    input  logic [7:0]         wr_data,
    input  logic               line_start,
    input  logic [LINE_W-1:0]  scanline,
    input  logic [OUTER_W-1:0] outer_prg,
    input  logic               mirror_sel,
    output logic [PRG_W-1:0]   prg_bank,
    output logic [CHR_W-1:0]   chr_lo_bank,
    output logic [CHR_W-1:0]   chr_hi_bank,
    output logic               mirror_horiz
);

    logic [3:0] bank_low;
    logic [1:0] bank_high;
    logic       split_en;
    logic       fill_off;

    csm_regs #(.WIN_TAG(WIN_TAG)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .wr_en       (wr_en),
        .cpu_addr_hi (cpu_addr_hi),
        .wr_data     (wr_data),
        .bank_low    (bank_low),
        .split_en    (split_en),
        .bank_high   (bank_high),
        .fill_off    (fill_off)
    );

    csm_prg #(.OUTER_W(OUTER_W), .PRG_W(PRG_W)) u_prg (
        .bank_low  (bank_low),
        .bank_high (bank_high),
        .fill_off  (fill_off),
        .outer_prg (outer_prg),
        .prg_bank  (prg_bank)
    );

    csm_chr_fsm #(
        .LINE_W     (LINE_W),
        .CHR_W      (CHR_W),
        .SPLIT_LINE (SPLIT_LINE),
        .VIS_END    (VIS_END)
    ) u_chr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .line_start  (line_start),
        .scanline    (scanline),
        .split_en    (split_en),
        .chr_lo_bank (chr_lo_bank),
        .chr_hi_bank (chr_hi_bank)
    );

    assign mirror_horiz = mirror_sel;

endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int         OUTER_W = 8,
    parameter int         PRG_W   = 8,
    parameter int         LINE_W  = 9,
    parameter int         CHR_W   = 4,
    parameter int         VIS_END = 239,
    parameter logic [5:0] WIN_TAG = 6'b010100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear,
    input logic               wr_en,
    input logic [7:0]         cpu_addr_hi,
    input logic               line_start,
    input logic [LINE_W-1:0]  scanline,
    input logic [OUTER_W-1:0] outer_prg,
    input logic [PRG_W-1:0]   prg_bank,
    input logic [CHR_W-1:0]   chr_lo_bank,
    input logic [CHR_W-1:0]   chr_hi_bank
);

    logic hit;
    assign hit = wr_en && (cpu_addr_hi[7:2] == WIN_TAG);

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !hit) |=> (!$stable(outer_prg) || $stable(prg_bank))); // R1

    AST_CHR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_lo_bank == chr_hi_bank) ||
        (chr_lo_bank == CHR_W'(0) && chr_hi_bank == CHR_W'(1))); // R4

    AST_BLANK_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && scanline >= LINE_W'(VIS_END)) |=>
        (chr_lo_bank == CHR_W'(0) && chr_hi_bank == CHR_W'(1))); // R6

    AST_CHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !clear) |=> ($stable(chr_lo_bank) && $stable(chr_hi_bank))); // R7

    AST_CLEAR_PRG: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (prg_bank == (PRG_W'(2'b11) | PRG_W'($past(outer_prg) >> 2)) ||
                   !$stable(outer_prg))); // R9

    AST_CLEAR_CHR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (chr_lo_bank == CHR_W'(0) && chr_hi_bank == CHR_W'(1))); // R9

endmodule

bind chr_split_mapper csm_checker #(
    .OUTER_W (OUTER_W),
    .PRG_W   (PRG_W),
    .LINE_W  (LINE_W),
    .CHR_W   (CHR_W),
    .VIS_END (VIS_END),
    .WIN_TAG (WIN_TAG)
) u_csm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .wr_en       (wr_en),
    .cpu_addr_hi (cpu_addr_hi),
    .line_start  (line_start),
    .scanline    (scanline),
    .outer_prg   (outer_prg),
    .prg_bank    (prg_bank),
    .chr_lo_bank (chr_lo_bank),
    .chr_hi_bank (chr_hi_bank)
);

// File: tb/test_chr_split_mapper.sv
module test_chr_split_mapper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] cpu_addr_hi = '0;
    logic [7:0] wr_data = '0;
    logic       line_start = 1'b0;
    logic [8:0] scanline = '0;
    logic [7:0] outer_prg = '0;
    logic       mirror_sel = 1'b0;
    logic [7:0] prg_bank;
    logic [3:0] chr_lo_bank, chr_hi_bank;
    logic       mirror_horiz;

    always #10 clk = ~clk;

    chr_split_mapper i_chr_split_mapper (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
        .cpu_addr_hi(cpu_addr_hi), .wr_data(wr_data), .line_start(line_start),
        .scanline(scanline), .outer_prg(outer_prg), .mirror_sel(mirror_sel),
        .prg_bank(prg_bank), .chr_lo_bank(chr_lo_bank), .chr_hi_bank(chr_hi_bank),
        .mirror_horiz(mirror_horiz)
    );

    typedef struct packed {
        logic [7:0] prg;
        logic [3:0] lo;
        logic [3:0] hi;
        logic       mir;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  sample_ev;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    // bench model
    logic [7:0] m_reg [4];
    logic [3:0] m_lo = 4'd0, m_hi = 4'd1;

    function automatic logic [7:0] model_prg();
        logic [7:0] v;
        v = {2'b00, m_reg[2][1:0], 4'b0000} | {4'b0000, m_reg[0][3:0]};
        v = v | (m_reg[3][2] ? 8'h00 : 8'h03) | (outer_prg >> 2);
        return v;
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        e.prg = model_prg();
        e.lo  = m_lo;
        e.hi  = m_hi;
        e.mir = mirror_sel;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> sample_ev;
        #1;
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (prg_bank !== e.prg || chr_lo_bank !== e.lo ||
                    chr_hi_bank !== e.hi || mirror_horiz !== e.mir) begin
                    n_fail++;
                    $display("FAIL %s: actual prg=%h lo=%0d hi=%0d mir=%b expected prg=%h lo=%0d hi=%0d mir=%b",
                             t, prg_bank, chr_lo_bank, chr_hi_bank, mirror_horiz,
                             e.prg, e.lo, e.hi, e.mir);
                end
            end
        end
    end

    task automatic cpu_write(input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        cpu_addr_hi = addr[15:8];
        wr_data     = data;
        wr_en       = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr[15:10] == 6'b010100) m_reg[addr[9:8]] = data;
    endtask

    task automatic strobe_line(input int line);
        @(negedge clk);
        scanline   = 9'(line);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (!m_reg[0][7] || line >= 239) begin
            m_lo = 4'd0; m_hi = 4'd1;
        end else if (line >= 127) begin
            m_lo = 4'd1; m_hi = 4'd1;
        end else begin
            m_lo = 4'd0; m_hi = 4'd0;
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        m_lo = 4'd0; m_hi = 4'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R9 reset state");

        cpu_write(16'h5000, 8'h05);
        expect_now("R2 reg0 low nibble");
        cpu_write(16'h5300, 8'h04);
        expect_now("R3 fill disabled");
        cpu_write(16'h5203, 8'h01);
        expect_now("R2 reg2 field via aliased address");
        @(negedge clk);
        outer_prg = 8'h80;
        @(negedge clk);
        expect_now("R2 outer offset or-in");
        cpu_write(16'h5300, 8'h00);
        expect_now("R3 fill enabled");

        cpu_write(16'h5400, 8'hFF);
        expect_now("R1 write above window ignored");
        cpu_write(16'h4F00, 8'hFF);
        expect_now("R1 write below window ignored");

        cpu_write(16'h5000, 8'h82);
        expect_now("R7 write alone keeps CHR");
        strobe_line(10);
        expect_now("R4 split top");
        @(negedge clk);
        scanline = 9'd200;
        repeat (3) @(negedge clk);
        expect_now("R7 scanline change without strobe");
        strobe_line(126);
        expect_now("R4 line 126");
        strobe_line(127);
        expect_now("R5 line 127");
        strobe_line(238);
        expect_now("R5 line 238");
        strobe_line(239);
        expect_now("R6 line 239");
        strobe_line(250);
        expect_now("R6 vblank line");
        strobe_line(130);
        expect_now("R5 back in split");
        cpu_write(16'h5000, 8'h02);
        expect_now("R7 split disable waits for strobe");
        strobe_line(130);
        expect_now("R6 split disabled");

        @(negedge clk);
        mirror_sel = 1'b1;
        #1;
        expect_now("R8 horizontal");
        @(negedge clk);
        mirror_sel = 1'b0;
        #1;
        expect_now("R8 vertical");

        cpu_write(16'h5000, 8'h8F);
        cpu_write(16'h5200, 8'h03);
        strobe_line(140);
        expect_now("R5 setup before clear");
        pulse_clear();
        expect_now("R9 clear");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule